// File: doc/BRIEF.md
# Reuse-Distance Locality Histogram

This block watches a stream of word addresses and builds, in a single pass, a table of temporal locality for several block sizes at once. For each block-size exponent b from 0 to a parameterised maximum, the block number is the address with its b low bits removed. For each accepted address and each b, the block looks up how many distinct blocks were touched since the previous use of the same block, counting that block itself. An immediate re-reference therefore has distance 1. The cell for (b, distance) is then incremented. A block seen for the first time, or reused only after more distinct blocks than the tracking depth, goes to a separate cold/overflow counter.

Software or a test harness reads the table after a run through a simple combinational read port. Because the table is kept per distance rather than per cache size, the misses of every fully associative cache of n lines of 2^b words follow from one table: total references minus the sum of cells at distances 1 through n. A synchronous clear empties the table and the recency tracking between runs. One address is accepted per cycle, and every block size is updated in that same cycle.

Top module: `lds_locality_hist`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, every histogram cell and every cold/overflow counter reads 0. A block referenced after a clear counts as cold, even if it was seen before the clear.
- R2: At exponent b, two addresses belong to the same block exactly when `addr >> b` is equal. So addresses 8, 9 and 15 form one block at b = 3 and distinct blocks at b = 0.
- R3: For a reuse, the distance is the number of distinct blocks referenced since the previous use of that block, the block itself included. Cell (b, d) is read at `rd_exp` = b, `rd_dist` = d (1..DEPTH). A back-to-back repeat of one address increments distance 1 at every b.
- R4: A first reference, or a reuse whose distance would exceed DEPTH (16), increments the cold/overflow counter of that b, which is read at `rd_dist` = 0. A reuse at exactly distance 16 still lands in cell 16.
- R5: At b = 0 the block trace 0,1,2,0,1,0,2 yields L(0,1)=0, L(0,2)=1, L(0,3)=3, L(0,4)=0 and a cold count of 3.
- R6: Counters are CNT_W bits wide and saturate at all ones; further events leave a saturated counter unchanged.
- R7: `in_ready` is low in any cycle in which `clr` is high. An address is counted only when `in_valid` and `in_ready` are both high; addresses presented otherwise leave every counter unchanged.
- R8: A read with `rd_dist` greater than DEPTH, or with `rd_exp` greater than MAX_EXP, returns 0.
- R9: Each accepted address updates the tables of all exponents 0..MAX_EXP in the same cycle. For an arbitrary stream, every cell matches the distinct-block distance definition applied separately at each b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters and recency state |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block can take an address this cycle (low during clear) |
| in_addr | input | ADDR_W | Word address |
| rd_exp | input | EXP_W | Block-size exponent to read |
| rd_dist | input | DIST_W | Distance to read; 0 selects the cold/overflow counter |
| rd_count | output | CNT_W | Selected counter value |

## Verification
A corrupted recency stack does not show up at once. It shows up the next time the affected block or one of the blocks behind it is reused: that count lands in the wrong distance cell or in the cold counter. A long mixed stream is therefore compared cell by cell against an independent distinct-block count, so that stale state has time to surface. Counter faults show up on the next read of the affected cell. A missed clear shows up at the first reference that should have been cold.

// File: rtl/lds_pkg.sv
// Package: default sizes shared by the locality histogram and its bench.
// Assumes nothing; holds constants only.
package lds_pkg;
    localparam int LDS_ADDR_W  = 16;  // word address width
    localparam int LDS_MAX_EXP = 3;   // largest block-size exponent
    localparam int LDS_DEPTH   = 16;  // distances tracked per exponent
    localparam int LDS_CNT_W   = 32;  // counter width
endpackage

// File: rtl/lds_recency_stack.sv
// Module: recency stack for one block size.
// Holds the DEPTH most recently used block tags, most recent at entry 0.
// On a push it reports whether the tag is present and at which position
// (0-based), then moves the tag to the top. Entries below the match keep
// their places. On a miss every entry moves down one place and the last
// one is dropped.
// Assumes: tags in the stack are unique (kept so by this update rule).
module lds_recency_stack #(
    parameter int TAG_W = 16,
    parameter int DEPTH = 16,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [POS_W-1:0] hit_pos
);
    logic [TAG_W-1:0] ent [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] match;

    // Compare the incoming tag with every valid entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = vld[i] && (ent[i] == tag);
        end
    end

    // Encode the matching position; the first one found wins.
    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_pos = POS_W'(i);
            end
        end
    end

    // Move the referenced tag to the top and shift the entries above its old place.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (push) begin
            ent[0] <= tag;
            vld[0] <= 1'b1;
            for (int i = 1; i < DEPTH; i++) begin
                if (!hit || (i <= int'(hit_pos))) begin
                    ent[i] <= ent[i-1];
                    vld[i] <= vld[i-1];
                end
            end
        end
    end

    // R3: a tag is never stored twice, so at most one entry matches
    // R3
    stack_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R3: after a push, the pushed tag is the valid top entry
    // R3
    stack_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> (vld[0] && ent[0] == $past(tag)));

    // R4: a hit keeps the number of occupied entries unchanged
    // R4
    stack_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && hit && !clr) |=> ($countones(vld) == $past($countones(vld))));
endmodule

// File: rtl/lds_hist_bank.sv
// Module: histogram counters for one block size.
// Cell 0 is the cold/overflow counter; cells 1..DEPTH count reuses at
// that distance. Counters saturate at all ones. A combinational read
// port returns one cell; an index above DEPTH reads 0.
// Assumes: hit_pos is the 0-based stack position of the reused block.
module lds_hist_bank #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 32,
    localparam int POS_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DIST_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic              hit,
    input  logic [POS_W-1:0]  hit_pos,
    input  logic [DIST_W-1:0] rd_dist,
    output logic [CNT_W-1:0]  rd_count
);
    logic [CNT_W-1:0]  cnt [DEPTH+1];
    logic [DIST_W-1:0] sel;

    // Pick the cell to bump: distance is position plus one, a miss goes to cell 0.
    always_comb begin
        sel = hit ? (DIST_W'(hit_pos) + DIST_W'(1)) : '0;
    end

    // Bump the selected cell unless it is already saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i <= DEPTH; i++) cnt[i] <= '0;
        end else if (inc) begin
            for (int i = 0; i <= DEPTH; i++) begin
                if ((int'(sel) == i) && (cnt[i] != '1)) cnt[i] <= cnt[i] + 1'b1;
            end
        end
    end

    // Return the addressed cell, or 0 beyond the table.
    always_comb begin
        rd_count = '0;
        for (int i = 0; i <= DEPTH; i++) begin
            if (int'(rd_dist) == i) rd_count = cnt[i];
        end
    end

    // R6: a saturated cold counter stays saturated until a clear
    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[0] == '1 && !clr) |=> (cnt[0] == '1));

    // R6: the cold counter never goes down without a clear
    // R6
    cold_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt[0] >= $past(cnt[0])));

    // R4: a miss bumps the cold counter by exactly one while below saturation
    // R4
    cold_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !hit && !clr && cnt[0] != '1) |=> (cnt[0] == $past(cnt[0]) + 1'b1));
endmodule

// File: rtl/lds_locality_hist.sv
// Module: reuse-distance locality histogram, top level.
// Splits each accepted address into a block number for every exponent
// 0..MAX_EXP. Each exponent gets its own recency stack and counter bank,
// and all of them update in the same cycle. The read port selects the
// bank by exponent and the cell by distance.
// Assumes: one address per cycle at most; clear takes priority over input.
module lds_locality_hist
    import lds_pkg::*;
#(
    parameter int ADDR_W  = LDS_ADDR_W,
    parameter int MAX_EXP = LDS_MAX_EXP,
    parameter int DEPTH   = LDS_DEPTH,
    parameter int CNT_W   = LDS_CNT_W,
    localparam int NUM_EXP = MAX_EXP + 1,
    localparam int EXP_W   = (NUM_EXP > 1) ? $clog2(NUM_EXP) + 1 : 1,
    localparam int DIST_W  = $clog2(DEPTH + 1),
    localparam int POS_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [EXP_W-1:0]  rd_exp,
    input  logic [DIST_W-1:0] rd_dist,
    output logic [CNT_W-1:0]  rd_count
);
    logic             accept;
    logic [CNT_W-1:0] bank_count [NUM_EXP];

    // Refuse input while clearing; accept on a valid/ready handshake.
    always_comb begin
        in_ready = !clr;
        accept   = in_valid && in_ready;
    end

    for (genvar b = 0; b < NUM_EXP; b++) begin : g_exp
        localparam int TAG_W = ADDR_W - b;
        logic             hit;
        logic [POS_W-1:0] hit_pos;

        lds_recency_stack #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_stack (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .push    (accept),
            .tag     (in_addr[ADDR_W-1:b]),
            .hit     (hit),
            .hit_pos (hit_pos)
        );

        lds_hist_bank #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .inc      (accept),
            .hit      (hit),
            .hit_pos  (hit_pos),
            .rd_dist  (rd_dist),
            .rd_count (bank_count[b])
        );
    end

    // Route the bank chosen by the exponent to the read port, 0 if out of range.
    always_comb begin
        rd_count = '0;
        for (int b = 0; b < NUM_EXP; b++) begin
            if (int'(rd_exp) == b) rd_count = bank_count[b];
        end
    end

    // R7
    ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !in_ready);

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (rd_count == '0));

    // R8
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_dist) > DEPTH) |-> (rd_count == '0));
endmodule

// File: tb/tb_lds_locality_hist.sv
`timescale 1ns/100ps
module tb_lds_locality_hist;
    localparam int AW = 16;
    localparam int NE = 4;
    localparam int DP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready, sat_ready;
    logic [AW-1:0] in_addr = '0;
    logic [2:0]  rd_exp = '0;
    logic [4:0]  rd_dist = '0;
    logic [31:0] rd_count;
    logic [3:0]  sat_count;

    always #2.5 clk = ~clk;

    lds_locality_hist dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_ready(in_ready), .in_addr(in_addr), .rd_exp(rd_exp),
        .rd_dist(rd_dist), .rd_count(rd_count));

    lds_locality_hist #(.CNT_W(4)) dut_sat (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_ready(sat_ready), .in_addr(in_addr), .rd_exp(rd_exp),
        .rd_dist(rd_dist), .rd_count(sat_count));

    typedef struct {
        bit     sat;
        longint exp;
        string  tag;
        int     b;
        int     d;
    } item_t;

    item_t  sbq[$];
    int     n_chk = 0;
    int     n_bad = 0;
    bit     done = 1'b0;
    int     hist_a[$];
    longint exp_cnt [NE][DP+1];

    // Monitor: pop each expected item and compare it with the read port.
    always @(negedge clk) begin
        item_t  it;
        longint act;
        #1;
        if (sbq.size() > 0) begin
            it  = sbq.pop_front();
            act = it.sat ? longint'(sat_count) : longint'(rd_count);
            n_chk++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s b=%0d d=%0d actual=%0d expected=%0d",
                         it.tag, it.b, it.d, act, it.exp);
            end
        end
    end

    // Reference: distinct-block distance from the raw history, per exponent.
    task automatic model_ref(input int a);
        for (int b = 0; b < NE; b++) begin
            int x = a >> b;
            int d = 0;
            int seen[$];
            for (int j = hist_a.size() - 1; j >= 0; j--) begin
                int y = hist_a[j] >> b;
                bit known = 1'b0;
                if (y == x) begin
                    d = seen.size() + 1;
                    break;
                end
                foreach (seen[k]) if (seen[k] == y) known = 1'b1;
                if (!known) seen.push_back(y);
                if (seen.size() >= DP) break;
            end
            exp_cnt[b][d] = exp_cnt[b][d] + 1;
        end
        hist_a.push_back(a);
    endtask

    task automatic model_clear();
        hist_a.delete();
        for (int b = 0; b < NE; b++)
            for (int d = 0; d <= DP; d++) exp_cnt[b][d] = 0;
    endtask

    // Driver: offer one address for one cycle and record it in the model.
    task automatic send(input int a);
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = AW'(a);
        model_ref(a);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Driver: select a cell and queue its expected value for the monitor.
    task automatic chk(input bit sat, input int b, input int d,
                       input longint e, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b0;
        rd_exp   = 3'(b);
        rd_dist  = 5'(d);
        it.sat = sat; it.exp = e; it.tag = tag; it.b = b; it.d = d;
        sbq.push_back(it);
    endtask

    // Clear while an address is offered; that address must be refused.
    task automatic do_clear(input int a);
        @(negedge clk);
        clr      = 1'b1;
        in_valid = 1'b1;
        in_addr  = AW'(a);
        #1;
        n_chk++;
        if (in_ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 in_ready during clear actual=%0b expected=0", in_ready);
        end
        @(negedge clk);
        clr      = 1'b0;
        in_valid = 1'b0;
        model_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(0, 0, 0, 0, "R1");
        chk(0, 3, 16, 0, "R1");
        chk(0, 2, 1, 0, "R1");

        // R5: example trace at b=0
        send(0); send(1); send(2); send(0); send(1); send(0); send(2); idle();
        chk(0, 0, 1, 0, "R5");
        chk(0, 0, 2, 1, "R5");
        chk(0, 0, 3, 3, "R5");
        chk(0, 0, 4, 0, "R5");
        chk(0, 0, 0, 3, "R5");
        // R9: the same stream at b=1 is blocks 0,0,1,0,0,0,1
        chk(0, 1, 1, 3, "R9");
        chk(0, 1, 2, 2, "R9");
        chk(0, 1, 0, 2, "R9");

        // R1 and R7: clear with an address offered
        do_clear(16'h0040);
        chk(0, 0, 3, 0, "R1");
        chk(0, 3, 0, 0, "R1");
        send(16'h0040); idle();
        chk(0, 0, 0, 1, "R7");
        chk(0, 0, 1, 0, "R7");
        // R7: an address with in_valid low is ignored
        @(negedge clk);
        in_addr  = 16'h0040;
        in_valid = 1'b0;
        send(16'h0040); idle();
        chk(0, 0, 1, 1, "R7");

        // R2: block grouping
        do_clear(0);
        send(8); send(9); send(15); send(16); idle();
        chk(0, 3, 1, 2, "R2");
        chk(0, 3, 0, 2, "R2");
        chk(0, 0, 0, 4, "R2");
        chk(0, 2, 1, 1, "R2");

        // R4: distance 16 and overflow beyond it
        do_clear(0);
        for (int k = 0; k < 16; k++) send(k * 16);
        send(0); send(256); send(32); send(16); idle();
        chk(0, 0, 16, exp_cnt[0][16], "R4");
        chk(0, 0, 0, exp_cnt[0][0], "R4");
        chk(0, 3, 16, exp_cnt[3][16], "R4");
        chk(0, 3, 0, exp_cnt[3][0], "R4");

        // R8: out-of-range reads
        chk(0, 0, 17, 0, "R8");
        chk(0, 1, 31, 0, "R8");
        chk(0, 5, 0, 0, "R8");

        // R9: mixed stream compared at every exponent and distance
        do_clear(0);
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) idle();
            else send(int'(lfsr[6:0]));
        end
        idle();
        for (int b = 0; b < NE; b++)
            for (int d = 0; d <= DP; d++)
                chk(0, b, d, exp_cnt[b][d], "R9");

        // R6 and R3: saturation on a narrow instance, repeats at distance 1
        do_clear(0);
        for (int n = 0; n < 20; n++) send(7);
        idle();
        chk(0, 0, 1, 19, "R3");
        chk(0, 3, 1, 19, "R3");
        chk(1, 0, 1, 15, "R6");
        chk(1, 3, 1, 15, "R6");
        chk(1, 0, 0, 1, "R6");

        wait (sbq.size() == 0);
        @(negedge clk);
        #2;
        finish_run();
    end
endmodule